// File: doc/BRIEF.md
# Wiper Tap Switch Controller

This block drives the switch bank of a resistor ladder with one switch per tap. It turns a stored wiper code and a run/shutdown control into a one-hot vector of tap enables. It also drives two end-switch enables: one joins the ladder to its high end, and one shunts the wiper node to the low end. The analog ladder is not part of the block. Only the enables that steer it are.

New wiper codes arrive on a valid/ready interface. A code is accepted on the rising clock edge where `code_vld` and `code_rdy` are both high. The sender must hold `code_vld` and `code_dat` steady until that edge. `code_rdy` goes low in two cases: while a code accepted during a tap transition still waits to be applied, and during the single cycle of shutdown exit. A tap change switches in the new tap one cycle before it drops the old one, so the wiper always has a path.

Clearing `run` puts the block in shutdown. The ladder is opened and the wiper is shunted to the low end, but the stored code is kept. Setting `run` again brings back the tap for the stored code before the shunt is released. Codes accepted while in shutdown replace the stored code without moving any switch.

Top module: `wtap_switch_ctrl`

## Requirements
- R1: Bit k of `tap_en` is the switch for code k. Bit 0 is the tap nearest the low end, bit 255 the tap nearest the high end, and a larger code selects a tap further toward the high end.
- R2: While reset is held and right after it, only `tap_en[128]` is high, `hi_conn` is 1, `lo_shunt` is 0 and `code_rdy` is 1.
- R3: When an accepted code differs from the current tap, the old and new tap bits are both high for exactly one cycle, starting the cycle after acceptance. After that, only the new bit is high.
- R4: While `run` keeps the block out of shutdown, exactly one tap bit is high outside an overlap cycle, and never more than two are high.
- R5: One edge after `run` is sampled low, `tap_en` is all zero, `hi_conn` is 0 and `lo_shunt` is 1.
- R6: Shutdown keeps the stored code. A code accepted during shutdown replaces the stored code, and all outputs stay unchanged.
- R7: On leaving shutdown, the stored tap and `hi_conn` are high together with `lo_shunt` for exactly one cycle. Then `lo_shunt` falls.
- R8: A code accepted during an overlap cycle is latched. It is applied as a new overlap after exactly one single-tap cycle on the previous target. `code_rdy` is low while the latch is full and during the shutdown-exit cycle.
- R9: An accepted code equal to the current tap causes no change on any output.
- R10: If `run` falls during an overlap cycle, the transition completes to the new tap, and that tap is the one restored on exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| code_vld | input | 1 | A wiper code is offered |
| code_rdy | output | 1 | The block can take a code on this edge |
| code_dat | input | 8 | Offered wiper code |
| run | input | 1 | 1 for normal operation, 0 for shutdown |
| tap_en | output | 256 | One enable per ladder tap, bit index equals code |
| hi_conn | output | 1 | Connects the ladder to its high end |
| lo_shunt | output | 1 | Shunts the wiper to the low end |

## Verification
The hardest state to reach is the full latch. A second code must be accepted in the single overlap cycle, and a third must then be presented so that `code_rdy` is seen low. The stimulus gets there by keeping `code_vld` asserted across consecutive codes, so each new code lands on the edge right after the previous one was taken. Dropping `run` in the cycle just after an acceptance reaches the other narrow case: shutdown starting in the middle of a transition.

// File: rtl/wtap_pkg.sv
package wtap_pkg;
  // Control phases of the tap switch sequencer
  typedef enum logic [1:0] {
    S_HOLD = 2'd0, // one tap closed, ladder connected
    S_OVL  = 2'd1, // old and new taps both closed
    S_OFF  = 2'd2, // ladder open, wiper shunted low
    S_WAKE = 2'd3  // restored tap closed, shunt still held
  } wstate_t;
endpackage

// File: rtl/wtap_seq.sv
module wtap_seq
  import wtap_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              code_vld,
  output logic              code_rdy,
  input  logic [CODE_W-1:0] code_dat,
  input  logic              run,
  output wstate_t           st,
  output logic [CODE_W-1:0] cur,
  output logic [CODE_W-1:0] nxt
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

  logic [CODE_W-1:0] pend;
  logic              pend_v;
  logic              acc;
  logic [CODE_W-1:0] src;

  assign code_rdy = !pend_v && (st != S_WAKE);
  assign acc      = code_vld && code_rdy;
  // Target considered in the steady phase: latched code first
  assign src      = pend_v ? pend : (acc ? code_dat : cur);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_HOLD;
      cur    <= MID;
      nxt    <= MID;
      pend   <= MID;
      pend_v <= 1'b0;
    end else begin
      case (st)
        S_HOLD: begin
          pend_v <= 1'b0;
          if (!run) begin
            st  <= S_OFF;
            cur <= src;
          end else if (src != cur) begin
            st  <= S_OVL;
            nxt <= src;
          end
        end
        S_OVL: begin
          cur <= nxt;
          if (!run) begin
            st <= S_OFF;
            if (acc) cur <= code_dat;
          end else begin
            st <= S_HOLD;
            if (acc) begin
              pend   <= code_dat;
              pend_v <= 1'b1;
            end
          end
        end
        S_OFF: begin
          if (acc) cur <= code_dat;
          if (run) st <= S_WAKE;
        end
        default: begin
          st <= run ? S_HOLD : S_OFF;
        end
      endcase
    end
  end
endmodule

// File: rtl/wtap_decode.sv
module wtap_decode #(
  parameter int CODE_W = 8,
  localparam int TAPS  = 1 << CODE_W
) (
  input  logic [CODE_W-1:0] a,
  input  logic [CODE_W-1:0] b,
  input  logic              act,
  input  logic              sec,
  output logic [TAPS-1:0]   en
);
  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    assign en[i] = act && ((a == CODE_W'(i)) || (sec && (b == CODE_W'(i))));
  end
endmodule

// File: rtl/wtap_switch_ctrl.sv
module wtap_switch_ctrl
  import wtap_pkg::*;
#(
  parameter int CODE_W = 8,
  localparam int TAPS  = 1 << CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              code_vld,
  output logic              code_rdy,
  input  logic [CODE_W-1:0] code_dat,
  input  logic              run,
  output logic [TAPS-1:0]   tap_en,
  output logic              hi_conn,
  output logic              lo_shunt
);
  wstate_t           st;
  logic [CODE_W-1:0] cur;
  logic [CODE_W-1:0] nxt;

  wtap_seq #(.CODE_W(CODE_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .code_vld (code_vld),
    .code_rdy (code_rdy),
    .code_dat (code_dat),
    .run      (run),
    .st       (st),
    .cur      (cur),
    .nxt      (nxt)
  );

  wtap_decode #(.CODE_W(CODE_W)) u_dec (
    .a   (cur),
    .b   (nxt),
    .act (st != S_OFF),
    .sec (st == S_OVL),
    .en  (tap_en)
  );

  assign hi_conn  = (st != S_OFF);
  assign lo_shunt = (st == S_OFF) || (st == S_WAKE);
endmodule

// File: rtl/wtap_switch_chk.sv
module wtap_switch_chk #(
  parameter int CODE_W = 8,
  localparam int TAPS  = 1 << CODE_W
) (
  input logic            clk,
  input logic            rst_n,
  input logic            code_rdy,
  input logic [TAPS-1:0] tap_en,
  input logic            hi_conn,
  input logic            lo_shunt
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  p_overlap_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(tap_en) == 2) |=> ($countones(tap_en) <= 1));

  p_tap_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_conn && !lo_shunt) |-> ($countones(tap_en) >= 1 && $countones(tap_en) <= 2));

  p_make_before_break_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && hi_conn && $past(hi_conn) && (tap_en != $past(tap_en)))
      |-> ((tap_en & $past(tap_en)) != '0));

  p_open_ladder_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_conn |-> (tap_en == '0 && lo_shunt));

  p_shunt_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $fell(lo_shunt)) |-> ($past(hi_conn) && $past(tap_en) != '0));

  p_wake_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_conn && lo_shunt) |-> !code_rdy);
endmodule

bind wtap_switch_ctrl wtap_switch_chk #(.CODE_W(CODE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .code_rdy (code_rdy),
  .tap_en   (tap_en),
  .hi_conn  (hi_conn),
  .lo_shunt (lo_shunt)
);

// File: tb/sim_wtap_switch_ctrl.sv
module sim_wtap_switch_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int TAPS = 256;

  typedef struct packed {
    logic [8:0] cnt;
    logic [7:0] lo;
    logic [7:0] hg;
    logic       h;
    logic       s;
  } obs_t;

  typedef struct {
    obs_t  o;
    int    dur;
    string tag;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            code_vld = 1'b0;
  logic [7:0]      code_dat = 8'h00;
  logic            run = 1'b1;
  logic            code_rdy;
  logic [TAPS-1:0] tap_en;
  logic            hi_conn;
  logic            lo_shunt;

  int   total = 0;
  int   bad = 0;
  int   stalls = 0;
  bit   mon_on = 1'b0;
  bit   have = 1'b0;
  obs_t prev;
  int   len = 0;
  exp_t expq[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  wtap_switch_ctrl u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .code_vld (code_vld),
    .code_rdy (code_rdy),
    .code_dat (code_dat),
    .run      (run),
    .tap_en   (tap_en),
    .hi_conn  (hi_conn),
    .lo_shunt (lo_shunt)
  );

  function automatic obs_t sample();
    obs_t r;
    r = '0;
    for (int i = 0; i < TAPS; i++) begin
      if (tap_en[i]) begin
        if (r.cnt == 0) r.lo = 8'(i);
        r.hg  = 8'(i);
        r.cnt = r.cnt + 9'd1;
      end
    end
    r.h = hi_conn;
    r.s = lo_shunt;
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input string act, input string expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%s expected=%s", tag, act, expv);
    end
  endtask

  function automatic string ostr(obs_t o, int d);
    return $sformatf("{n=%0d lo=%0d hi=%0d conn=%0d shunt=%0d len=%0d}", o.cnt, o.lo, o.hg, o.h, o.s, d);
  endfunction

  task automatic push(input int n, input int lo, input int hg, input bit h, input bit s,
                      input int dur, input string tag);
    exp_t e;
    e.o.cnt = 9'(n);
    e.o.lo  = 8'(lo);
    e.o.hg  = 8'(hg);
    e.o.h   = h;
    e.o.s   = s;
    e.dur   = dur;
    e.tag   = tag;
    expq.push_back(e);
  endtask

  task automatic compare(input obs_t o, input int l, input bit final_one);
    exp_t e;
    if (expq.size() == 0) begin
      check(1'b0, "unexpected output change", ostr(o, l), "none");
    end else begin
      e = expq.pop_front();
      check((o == e.o) && (final_one || e.dur == 0 || e.dur == l), e.tag,
            ostr(o, l), ostr(e.o, e.dur));
    end
  endtask

  // Monitor: compresses each run of identical outputs and scores it
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on) begin
        obs_t o;
        o = sample();
        if (!have) begin
          prev = o;
          len  = 1;
          have = 1'b1;
        end else if (o == prev) begin
          len++;
        end else begin
          compare(prev, len, 1'b0);
          prev = o;
          len  = 1;
        end
      end
    end
  end

  // Caller is at a negedge; returns at the negedge after acceptance
  task automatic send(input logic [7:0] d);
    code_vld = 1'b1;
    code_dat = d;
    while (!code_rdy) begin
      stalls++;
      @(negedge clk);
    end
    @(negedge clk);
    code_vld = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (300) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    obs_t o;
    repeat (3) @(negedge clk);
    o = sample();
    check(o.cnt == 1 && tap_en[128] && hi_conn && !lo_shunt && code_rdy,
          "R2 state under reset", ostr(o, 0), "tap128 only, conn=1 shunt=0 rdy=1");
    rst_n = 1'b1;
    @(negedge clk);
    o = sample();
    check(o.cnt == 1 && tap_en[128] && hi_conn && !lo_shunt && code_rdy,
          "R2 state after reset", ostr(o, 0), "tap128 only, conn=1 shunt=0 rdy=1");

    push(1, 128, 128, 1, 0, 0, "R2 mid tap steady");
    mon_on = 1'b1;
    idle(2);

    // Down to the lowest tap, then up to the highest
    push(2, 0, 128, 1, 0, 1, "R3 overlap 128->0");
    push(1, 0, 0, 1, 0, 0, "R1 low-end tap 0");
    send(8'h00);
    idle(3);
    push(2, 0, 255, 1, 0, 1, "R3 overlap 0->255");
    push(1, 255, 255, 1, 0, 0, "R1 high-end tap 255");
    send(8'hFF);
    idle(3);

    // Back-to-back codes: latch and back-pressure
    push(2, 10, 255, 1, 0, 1, "R3 overlap 255->10");
    push(1, 10, 10, 1, 0, 1, "R8 single cycle on 10 before latched code");
    push(2, 10, 20, 1, 0, 1, "R8 latched overlap 10->20");
    push(1, 20, 20, 1, 0, 1, "R8 single cycle on 20 before next code");
    push(2, 20, 30, 1, 0, 1, "R8 overlap 20->30");
    push(1, 30, 30, 1, 0, 0, "R4 steady on 30");
    stalls = 0;
    send(8'd10);
    send(8'd20);
    send(8'd30);
    check(stalls >= 1, "R8 code_rdy low while latch full",
          $sformatf("stalls=%0d", stalls), ">=1");
    idle(4);

    // Same code again: nothing moves
    send(8'd30);
    idle(4);
    o = sample();
    check(o.cnt == 1 && tap_en[30] && hi_conn && !lo_shunt, "R9 repeated code no change",
          ostr(o, 0), "tap30 only conn=1 shunt=0");

    // Shutdown, new code inside it, then wake
    push(0, 0, 0, 0, 1, 0, "R5 ladder open in shutdown");
    run = 1'b0;
    idle(3);
    send(8'd200);
    idle(2);
    o = sample();
    check(o.cnt == 0 && !hi_conn && lo_shunt, "R6 code during shutdown leaves outputs",
          ostr(o, 0), "no tap conn=0 shunt=1");
    push(1, 200, 200, 1, 1, 1, "R7 wake cycle tap 200 with shunt");
    push(1, 200, 200, 1, 0, 0, "R6 restored stored tap 200");
    run = 1'b1;
    idle(4);

    // Shutdown that lands on an overlap cycle
    push(2, 50, 200, 1, 0, 1, "R10 overlap 200->50");
    push(0, 0, 0, 0, 1, 0, "R10 shutdown after overlap");
    push(1, 50, 50, 1, 1, 1, "R7 wake cycle tap 50 with shunt");
    push(1, 50, 50, 1, 0, 0, "R10 restored tap 50");
    send(8'd50);
    run = 1'b0;
    idle(4);
    run = 1'b1;
    idle(4);

    // Neighbours of mid-scale
    push(2, 50, 127, 1, 0, 1, "R3 overlap 50->127");
    push(1, 127, 127, 1, 0, 1, "R8 single cycle on 127");
    push(2, 127, 128, 1, 0, 1, "R1 overlap 127->128");
    push(1, 128, 128, 1, 0, 0, "R1 final tap 128");
    send(8'd127);
    send(8'd128);
    idle(4);

    mon_on = 1'b0;
    compare(prev, len, 1'b1);
    check(expq.size() == 0, "R4 all expected phases seen",
          $sformatf("left=%0d", expq.size()), "left=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule